// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block drives the word address and the word-valid timing for a synchronous burst read from a 16-bit memory array of 4M words. A burst starts when the address strobe is sampled high while chip enable is high. The block then waits a programmable number of cycles. After that it delivers one word address per cycle, with `word_valid` marking each delivered word. `busy` is high for the whole burst.

There are three burst shapes. Continuous linear runs on with no limit and rolls over from the top of the array to word zero. Wrap-8 and wrap-16 return each word of the aligned group that holds the start address, in ascending order from the start word. They wrap inside that group and stop after 8 or 16 words. At short latencies, a continuous burst that starts late in an aligned 8-word group takes one stall cycle when it first enters the next group.

The output side is a valid-only stream. There is no ready input and no back-pressure. The consumer must take the word on every cycle where `word_valid` is high, and `mem_addr` names that word in the same cycle.

Top module: `burst_read_seq`

## Requirements
- R1: In continuous mode (`burst_mode` 0, and also 3), each delivered address is the previous one plus one, modulo 2^22, so 3FFFFFh is followed by 000000h.
- R2: In wrap mode (`burst_mode` 1 = 8 words, 2 = 16 words), the burst returns exactly that many words. The first is the start address, the rest advance by one inside the aligned group, wrapping to the first word of the group. `busy` falls in the cycle after the last word.
- R3: If the strobe is sampled at clock edge n, the first word is valid in the cycle after edge n+L, where L is the stored latency. `word_valid` stays low before that.
- R4: The stored latency changes only through a write with `lat_wr_en` while `busy` is low and with a value from 3 to 9. Any other write is ignored. After reset the latency is 7.
- R5: In continuous mode, exactly one stall cycle, with `word_valid` low, follows the first delivered word at offset 7 of an 8-word group. This happens only when L=4 and the start offset is 5, 6 or 7, or when L=3 and the start offset is 6 or 7. No other case stalls, and wrap modes never stall.
- R6: Chip enable sampled low ends any burst, so `busy` and `word_valid` are low in the next cycle. A strobe with chip enable low starts nothing.
- R7: A strobe during a burst abandons that burst and starts a new one from the new address, with the full latency of R3.
- R8: `cmd_reset` has no effect on a running burst or on its latency. While idle it restores the latency to 7.
- R9: `word_valid` is high for exactly one cycle per delivered word, and `mem_addr` names that word in that cycle.
- R10: After reset, `busy` and `word_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_en | input | 1 | Chip enable; low ends a burst |
| addr_strobe | input | 1 | Starts a burst at `start_addr` |
| start_addr | input | 22 | First word address of the burst |
| burst_mode | input | 2 | 0/3 continuous, 1 wrap-8, 2 wrap-16; sampled with the strobe |
| lat_wr_en | input | 1 | Latency write request |
| lat_wr_val | input | 4 | Latency value to write (3 to 9) |
| cmd_reset | input | 1 | Command reset; restores latency 7 when idle |
| mem_addr | output | 22 | Address of the current word |
| word_valid | output | 1 | One pulse per delivered word |
| busy | output | 1 | A burst is in progress |

## Verification
Two things can fall in the same cycle. A latency write or a command reset can arrive while a burst is counting its initial latency, and a new strobe can arrive while a burst is streaming. The bench pulses a write of 9 and `cmd_reset` together during the wait. It then checks that the running burst keeps the timing of the old latency, and that a second burst still uses that latency. It also issues a strobe in the middle of a stream, then checks that valid words stop at once and resume after a full latency from the new address.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [1:0] {
    MODE_LINEAR = 2'd0,
    MODE_WRAP8  = 2'd1,
    MODE_WRAP16 = 2'd2,
    MODE_RSVD   = 2'd3
  } burst_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_STREAM = 2'd2
  } seq_state_e;
endpackage

// File: rtl/burst_lat_cfg.sv
module burst_lat_cfg #(
  parameter int LAT_W   = 4,
  parameter int LAT_MIN = 3,
  parameter int LAT_MAX = 9,
  parameter int LAT_DEF = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             wr_en,
  input  logic [LAT_W-1:0] wr_val,
  input  logic             cmd_reset,
  output logic [LAT_W-1:0] lat
);
  localparam logic [LAT_W-1:0] LMIN = LAT_W'(LAT_MIN);
  localparam logic [LAT_W-1:0] LMAX = LAT_W'(LAT_MAX);
  localparam logic [LAT_W-1:0] LDEF = LAT_W'(LAT_DEF);

  logic in_range;
  assign in_range = (wr_val >= LMIN) && (wr_val <= LMAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat <= LDEF;
    end else if (!busy) begin
      if (cmd_reset) lat <= LDEF;
      else if (wr_en && in_range) lat <= wr_val;
    end
  end

  // R4: latency frozen while a burst runs
  p_lat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(lat));
  // R4: stored latency always legal
  p_lat_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lat >= LMIN) && (lat <= LMAX));
endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W     = 22,
  parameter int WRAP_A_LOG = 3,
  parameter int WRAP_B_LOG = 4
) (
  input  logic [ADDR_W-1:0] cur,
  input  burst_mode_e       mode,
  output logic [ADDR_W-1:0] nxt
);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'((1 << WRAP_A_LOG) - 1);
  localparam logic [ADDR_W-1:0] MASK_B = ADDR_W'((1 << WRAP_B_LOG) - 1);

  logic [ADDR_W-1:0] mask;

  always_comb begin
    case (mode)
      MODE_WRAP8:  mask = MASK_A;
      MODE_WRAP16: mask = MASK_B;
      default:     mask = '1;
    endcase
    nxt = (cur & ~mask) | ((cur + ADDR_W'(1)) & mask);
  end
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W      = 22,
  parameter int LAT_W       = 4,
  parameter int WRAP_A_LOG  = 3,
  parameter int WRAP_B_LOG  = 4,
  parameter int STALL_LOG   = 3,
  parameter int STALL_LAT_A = 4,
  parameter int STALL_LAT_B = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              addr_strobe,
  input  logic [ADDR_W-1:0] start_addr,
  input  burst_mode_e       mode_in,
  input  logic [LAT_W-1:0]  lat,
  input  logic [ADDR_W-1:0] nxt_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output burst_mode_e       cur_mode,
  output logic              word_valid,
  output logic              busy
);
  localparam int CNT_W = WRAP_B_LOG + 1;
  localparam int GRP   = 1 << STALL_LOG;
  localparam logic [STALL_LOG-1:0] GRP_LAST = '1;
  localparam logic [STALL_LOG-1:0] OFF_A    = STALL_LOG'(GRP - 3);
  localparam logic [STALL_LOG-1:0] OFF_B    = STALL_LOG'(GRP - 2);
  localparam logic [CNT_W-1:0]     LEN_A    = CNT_W'(1 << WRAP_A_LOG);
  localparam logic [CNT_W-1:0]     LEN_B    = CNT_W'(1 << WRAP_B_LOG);

  seq_state_e            state;
  logic [LAT_W-1:0]      wait_cnt;
  logic [CNT_W-1:0]      left;
  logic                  stall_arm, stall_now, arm_start, lin_start;
  logic [STALL_LOG-1:0]  off;

  assign off       = start_addr[STALL_LOG-1:0];
  assign lin_start = (mode_in == MODE_LINEAR) || (mode_in == MODE_RSVD);
  assign arm_start = lin_start &&
                     (((lat == LAT_W'(STALL_LAT_A)) && (off >= OFF_A)) ||
                      ((lat == LAT_W'(STALL_LAT_B)) && (off >= OFF_B)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      wait_cnt  <= '0;
      left      <= '0;
      stall_arm <= 1'b0;
      stall_now <= 1'b0;
      cur_addr  <= '0;
      cur_mode  <= MODE_LINEAR;
    end else if (!chip_en) begin
      state     <= ST_IDLE;
      stall_now <= 1'b0;
    end else if (addr_strobe) begin
      state     <= ST_WAIT;
      wait_cnt  <= lat - LAT_W'(1);
      cur_addr  <= start_addr;
      cur_mode  <= lin_start ? MODE_LINEAR : mode_in;
      left      <= (mode_in == MODE_WRAP8) ? LEN_A : LEN_B;
      stall_arm <= arm_start;
      stall_now <= 1'b0;
    end else begin
      case (state)
        ST_WAIT: begin
          if (wait_cnt == '0) state <= ST_STREAM;
          else wait_cnt <= wait_cnt - LAT_W'(1);
        end
        ST_STREAM: begin
          if (stall_now) begin
            stall_now <= 1'b0;
          end else begin
            cur_addr <= nxt_addr;
            if (cur_mode != MODE_LINEAR) begin
              left <= left - CNT_W'(1);
              if (left == CNT_W'(1)) state <= ST_IDLE;
            end else if (stall_arm && (cur_addr[STALL_LOG-1:0] == GRP_LAST)) begin
              stall_now <= 1'b1;
              stall_arm <= 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign word_valid = (state == ST_STREAM) && !stall_now;
  assign busy       = (state != ST_IDLE);

  // R1: continuous stream steps by one, rolling over at the top
  p_lin_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && $past(word_valid) && cur_mode == MODE_LINEAR)
      |-> cur_addr == $past(cur_addr) + ADDR_W'(1));
  // R2: wrap-8 stays within its aligned group
  p_wrap_group_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && $past(word_valid) && cur_mode == MODE_WRAP8)
      |-> cur_addr[ADDR_W-1:WRAP_A_LOG] == $past(cur_addr[ADDR_W-1:WRAP_A_LOG]));
  // R5: a stall lasts one cycle and never happens in wrap modes
  p_stall_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_now && chip_en && !addr_strobe) |=> word_valid);
  p_wrap_no_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode != MODE_LINEAR) |-> !stall_now);
  // R6: chip enable low ends the burst
  p_ce_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> !busy);
  // R3: a strobe leads into a wait with no valid word
  p_strobe_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && addr_strobe) |=> (busy && !word_valid));
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int LAT_W   = 4,
  parameter int LAT_MIN = 3,
  parameter int LAT_MAX = 9,
  parameter int LAT_DEF = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              addr_strobe,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [1:0]        burst_mode,
  input  logic              lat_wr_en,
  input  logic [LAT_W-1:0]  lat_wr_val,
  input  logic              cmd_reset,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              word_valid,
  output logic              busy
);
  logic [LAT_W-1:0]  lat;
  logic [ADDR_W-1:0] nxt_addr;
  burst_mode_e       cur_mode;
  burst_mode_e       mode_in;

  assign mode_in = burst_mode_e'(burst_mode);

  burst_lat_cfg #(
    .LAT_W(LAT_W), .LAT_MIN(LAT_MIN), .LAT_MAX(LAT_MAX), .LAT_DEF(LAT_DEF)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .busy(busy), .wr_en(lat_wr_en),
    .wr_val(lat_wr_val), .cmd_reset(cmd_reset), .lat(lat)
  );

  burst_addr_step #(.ADDR_W(ADDR_W)) u_step (
    .cur(mem_addr), .mode(cur_mode), .nxt(nxt_addr)
  );

  burst_ctrl #(.ADDR_W(ADDR_W), .LAT_W(LAT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .addr_strobe(addr_strobe),
    .start_addr(start_addr), .mode_in(mode_in), .lat(lat), .nxt_addr(nxt_addr),
    .cur_addr(mem_addr), .cur_mode(cur_mode), .word_valid(word_valid), .busy(busy)
  );
endmodule

// File: tb/burst_read_seq_bench.sv
module burst_read_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chip_en = 1'b1;
  logic        addr_strobe = 1'b0;
  logic [21:0] start_addr = '0;
  logic [1:0]  burst_mode = '0;
  logic        lat_wr_en = 1'b0;
  logic [3:0]  lat_wr_val = '0;
  logic        cmd_reset = 1'b0;
  logic [21:0] mem_addr;
  logic        word_valid, busy;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  burst_read_seq u_burst_read_seq (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .addr_strobe(addr_strobe),
    .start_addr(start_addr), .burst_mode(burst_mode), .lat_wr_en(lat_wr_en),
    .lat_wr_val(lat_wr_val), .cmd_reset(cmd_reset), .mem_addr(mem_addr),
    .word_valid(word_valid), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input logic av, input logic [21:0] aa,
                       input logic ab, input logic ev, input logic [21:0] ea, input logic eb);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: valid=%0b addr=%h busy=%0b expected valid=%0b addr=%h busy=%0b",
               tag, av, aa, ab, ev, ea, eb);
    end
  endtask

  function automatic logic [21:0] exp_addr(logic [21:0] s, int m, int i);
    logic [21:0] mask;
    mask = (m == 1) ? 22'h7 : (m == 2) ? 22'hF : '1;
    return (s & ~mask) | ((s + 22'(i)) & mask);
  endfunction

  task automatic set_lat(input int v);
    @(negedge clk); lat_wr_en = 1'b1; lat_wr_val = 4'(v);
    @(negedge clk); lat_wr_en = 1'b0;
  endtask

  // Strobe a burst and check every cycle against the model.
  // disturb: pulse a latency write of 9 and cmd_reset during the wait (R4, R8)
  task automatic run_burst(input logic [21:0] s, input int m, input int L,
                           input int ncont, input bit disturb);
    int n, sidx, kend, j, i;
    logic ev, eb;
    logic [21:0] ea;
    string tag;
    bit lin;
    lin = (m == 0) || (m == 3);
    n = (m == 1) ? 8 : (m == 2) ? 16 : ncont;
    sidx = -1;
    if (lin && ((L == 4 && s[2:0] >= 5) || (L == 3 && s[2:0] >= 6))) sidx = 7 - int'(s[2:0]);
    if (sidx >= n - 1) sidx = -1;
    kend = L + n + ((sidx >= 0) ? 1 : 0);
    @(negedge clk); addr_strobe = 1'b1; start_addr = s; burst_mode = 2'(m);
    @(negedge clk); addr_strobe = 1'b0;
    for (int k = 1; k <= kend; k++) begin
      @(negedge clk);
      if (disturb && k == 3) begin lat_wr_en = 1'b0; cmd_reset = 1'b0; end
      j = k - L; ev = 1'b0; ea = mem_addr; eb = (k < kend);
      if (j < 0) tag = disturb ? "R8 latency wait" : "R3 latency wait";
      else if (sidx >= 0 && j == sidx + 1) tag = "R5 stall";
      else begin
        i = (sidx >= 0 && j > sidx + 1) ? j - 1 : j;
        if (i < n) begin ev = 1'b1; ea = exp_addr(s, m, i); end
        tag = (k == kend) ? (lin ? "R6 end" : "R2 end") : (lin ? "R1 stream" : "R2 stream");
      end
      check((word_valid === ev) && (busy === eb) && (!ev || mem_addr === ea),
            tag, word_valid, mem_addr, busy, ev, ea, eb);
      if (disturb && k == 2) begin lat_wr_en = 1'b1; lat_wr_val = 4'd9; cmd_reset = 1'b1; end
      if (lin && k == kend - 1) chip_en = 1'b0;
    end
    chip_en = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    if (!done) begin
      $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
      $finish;
    end
  end

  initial begin
    int lats[3] = '{3, 4, 7};
    int L, m;
    logic [21:0] base;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(!word_valid && !busy, "R10 reset", word_valid, mem_addr, busy, 0, mem_addr, 0);
    // R4 default latency 7
    run_burst(22'h000040, 0, 7, 10, 0);

    // every latency of interest, every mode, every start offset (R1, R2, R3, R5, R9)
    foreach (lats[li]) begin
      set_lat(lats[li]);
      for (int mm = 0; mm < 3; mm++)
        for (int off = 0; off < 8; off++) begin
          base = 22'($urandom) & ~22'hF;
          run_burst(base | 22'(off + ((mm == 2) ? 8 : 0)), mm, lats[li], 20, 0);
        end
    end

    // R1: rollover at the top of the array, mode code 3 also continuous
    set_lat(3);
    run_burst(22'h3FFFFA, 0, 3, 10, 0);
    run_burst(22'h3FFFFC, 3, 3, 8, 0);

    // R4: illegal values ignored
    set_lat(5); set_lat(2); set_lat(10);
    run_burst(22'h001235, 0, 5, 12, 0);
    set_lat(9);
    run_burst(22'h00ABC6, 2, 9, 1, 0);

    // R4, R8: write and cmd_reset during a burst ignored
    set_lat(3);
    run_burst(22'h000106, 0, 3, 12, 1);
    run_burst(22'h000203, 1, 3, 1, 0);
    // R8: cmd_reset while idle restores latency 7
    @(negedge clk); cmd_reset = 1'b1;
    @(negedge clk); cmd_reset = 1'b0;
    run_burst(22'h000300, 0, 7, 5, 0);

    // R7: strobe during a stream restarts the burst
    set_lat(4);
    @(negedge clk); addr_strobe = 1'b1; start_addr = 22'h000500; burst_mode = 2'd0;
    @(negedge clk); addr_strobe = 1'b0;
    repeat (6) @(negedge clk);
    check(word_valid && busy, "R7 first burst streaming", word_valid, mem_addr, busy, 1, mem_addr, 1);
    run_burst(22'h000777, 0, 4, 10, 0);

    // R6: chip enable drop in the middle of a wrap burst
    @(negedge clk); addr_strobe = 1'b1; start_addr = 22'h000A0B; burst_mode = 2'd2;
    @(negedge clk); addr_strobe = 1'b0;
    repeat (6) @(negedge clk);
    chip_en = 1'b0;
    @(negedge clk);
    check(!word_valid && !busy, "R6 chip enable drop", word_valid, mem_addr, busy, 0, mem_addr, 0);
    // R6: strobe with chip enable low starts nothing
    addr_strobe = 1'b1;
    @(negedge clk); addr_strobe = 1'b0;
    repeat (6) @(negedge clk);
    check(!word_valid && !busy, "R6 strobe ignored", word_valid, mem_addr, busy, 0, mem_addr, 0);
    chip_en = 1'b1;

    // constrained random bursts
    for (int r = 0; r < 40; r++) begin
      L = 3 + int'($urandom % 7);
      m = int'($urandom % 4);
      set_lat(L);
      run_burst(22'($urandom), m, L, 1 + int'($urandom % 24), 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule